// File: doc/BRIEF.md
# Two-Stage Converter Code Register Bank

This block is the register file between a serial write decoder and the converter channels of a multi-channel DAC. Each decoded write arrives as a one-cycle strobe. It carries a binary channel index, a 10-bit code, a 2-bit power field and a hold bit. Every channel has two stages. The staging register takes the code of each write to that channel. The output register drives the converter code.

A write with the hold bit high only fills a staging register. A write with the hold bit low is a load event. On that one clock edge, every channel whose staging register was written since the previous load copies it into its output register, so all changed outputs move together. Channels that were not written keep their output value, which avoids needless output activity. The written channel's own new code is part of the same transfer.

A small sequencer tracks whether any transfer is owed. It has two states. SEQ_CLEAN means no channel is pending. SEQ_PENDING means at least one staged code is waiting. The transitions are:
- CLEAN to PENDING on a held write to a valid channel.
- PENDING or CLEAN to CLEAN on any load write.
- Otherwise, stay in the current state.

The sequencer issues the transfer pulse. The power field is stored per channel and takes effect on the write itself.

Top module: `dac_dbuf_bank`

## Requirements
- R1: A synchronous reset clears, from the next edge on, every output code to 0, every power mode to 00 (normal) and every pending flag. A load after reset therefore changes no code that was only staged before reset.
- R2: A write with `wr_hold` = 1 stores its code in the staging register of channel `wr_chan` only. No output code changes on that edge.
- R3: A write with `wr_hold` = 0 stores its code and transfers it. The code appears on that channel's output one clock edge after the strobe. On the same edge, every other pending channel also transfers.
- R4: On a load, a channel that has not been written since the previous load keeps its output code.
- R5: A channel stays pending from a write until the next load. If the channel is written several times before the load, the last code written is the one transferred.
- R6: The power field `wr_pd` encodes 00 normal, 01 off with 1 kΩ to ground, 10 off with 100 kΩ to ground, and 11 off with high-impedance output. It appears on the addressed channel's mode output one edge after the write, whatever the value of the hold bit.
- R7: Changing a channel's power mode leaves its output code unchanged.
- R8: The outputs are packed by channel. Channel i's code is on `dac_code[i*10 +: 10]` and its mode is on `pd_mode[i*2 +: 2]`. `wr_chan` is the binary channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_chan | input | CHAN_W | Channel index of the write |
| wr_code | input | CODE_W | Code to stage |
| wr_pd | input | 2 | Power mode field |
| wr_hold | input | 1 | 1 = stage only; 0 = load all pending channels |
| dac_code | output | N_CH*CODE_W | Per-channel output codes |
| pd_mode | output | N_CH*2 | Per-channel power modes |

## Verification
A pending flag that is wrongly set or wrongly cleared shows nothing until the next load. At that load, a channel changes code when it should not, or keeps a stale code. This is visible one edge after the load strobe. Staging data that leaks into an output is seen on the edge right after the held write. A corrupted power mode shows one edge after the write that set it. The bench therefore follows every held write and every load with a full compare of all channels.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    localparam int CODE_W = 10;
    localparam int PD_W   = 2;

    typedef enum logic [PD_W-1:0] {
        PWR_ON   = 2'b00,
        PWR_1K   = 2'b01,
        PWR_100K = 2'b10,
        PWR_HIZ  = 2'b11
    } pwr_mode_e;

    typedef enum logic {
        SEQ_CLEAN   = 1'b0,
        SEQ_PENDING = 1'b1
    } seq_state_e;
endpackage

// File: rtl/dbuf_seq.sv
module dbuf_seq
    import dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_hold,
    input  logic wr_valid,
    output logic xfer_o,
    output logic pending_o
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_CLEAN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_CLEAN: begin
                if (wr_en && wr_hold && wr_valid) state_d = SEQ_PENDING;
            end
            SEQ_PENDING: begin
                if (wr_en && !wr_hold) state_d = SEQ_CLEAN;
            end
            default: state_d = SEQ_CLEAN;
        endcase
    end

    always_comb begin
        xfer_o    = wr_en && !wr_hold;
        pending_o = (state_q == SEQ_PENDING);
    end

    // R3
    load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_hold) |=> (state_q == SEQ_CLEAN));
endmodule

// File: rtl/dbuf_chan.sv
module dbuf_chan
    import dbuf_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_i,
    input  logic [W-1:0]    code_i,
    input  logic [PD_W-1:0] pd_i,
    input  logic            xfer_i,
    output logic [W-1:0]    dac_o,
    output logic [PD_W-1:0] pd_o,
    output logic            dirty_o
);
    logic [W-1:0] stage_q;
    logic [W-1:0] dac_q;
    logic         dirty_q;
    pwr_mode_e    pd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            dac_q   <= '0;
            dirty_q <= 1'b0;
            pd_q    <= PWR_ON;
        end else begin
            if (sel_i) begin
                stage_q <= code_i;
                pd_q    <= pwr_mode_e'(pd_i);
            end
            if (xfer_i) begin
                dirty_q <= 1'b0;
                if (sel_i)        dac_q <= code_i;
                else if (dirty_q) dac_q <= stage_q;
            end else if (sel_i) begin
                dirty_q <= 1'b1;
            end
        end
    end

    always_comb begin
        dac_o   = dac_q;
        pd_o    = pd_q;
        dirty_o = dirty_q;
    end

    // R4
    clean_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && !dirty_q && !sel_i) |=> $stable(dac_q));
    // R3
    own_code_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && sel_i) |=> (dac_q == $past(code_i)));
    // R5
    stays_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_i && !xfer_i) |=> dirty_q);
    // R6
    mode_takes_chk: assert property (@(posedge clk) disable iff (rst)
        sel_i |=> (pd_q == $past(pd_i)));
endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank
    import dbuf_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int CW     = CODE_W,
    parameter int CHAN_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CHAN_W-1:0]    wr_chan,
    input  logic [CW-1:0]        wr_code,
    input  logic [PD_W-1:0]      wr_pd,
    input  logic                 wr_hold,
    output logic [N_CH*CW-1:0]   dac_code,
    output logic [N_CH*PD_W-1:0] pd_mode
);
    localparam int IDX_W = CHAN_W + 1;

    logic            wr_valid;
    logic            xfer;
    logic            pending;
    logic [N_CH-1:0] dirty;

    assign wr_valid = ({1'b0, wr_chan} < IDX_W'(N_CH));

    dbuf_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_hold  (wr_hold),
        .wr_valid (wr_valid),
        .xfer_o   (xfer),
        .pending_o(pending)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic sel;
        assign sel = wr_en && (wr_chan == CHAN_W'(i));
        dbuf_chan #(.W(CW)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .sel_i  (sel),
            .code_i (wr_code),
            .pd_i   (wr_pd),
            .xfer_i (xfer),
            .dac_o  (dac_code[i*CW +: CW]),
            .pd_o   (pd_mode[i*PD_W +: PD_W]),
            .dirty_o(dirty[i])
        );
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && pd_mode == '0 && dirty == '0));
    // R2
    hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hold) |=> $stable(dac_code));
    // R5
    clean_state_chk: assert property (@(posedge clk) disable iff (rst)
        !pending |-> (dirty == '0));
    // R7
    mode_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!xfer) |=> $stable(dac_code));
endmodule

// File: tb/sim_dac_dbuf_bank.sv
module sim_dac_dbuf_bank;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [0:0] wr_chan;
    logic [9:0] wr_code;
    logic [1:0] wr_pd;
    logic       wr_hold;
    logic [19:0] dac_code;
    logic [3:0]  pd_mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dac_dbuf_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_code(wr_code), .wr_pd(wr_pd), .wr_hold(wr_hold),
        .dac_code(dac_code), .pd_mode(pd_mode)
    );

    typedef struct packed {
        logic       en;
        logic       ch;
        logic [9:0] code;
        logic [1:0] pd;
        logic       hold;
        logic [9:0] e0;
        logic [9:0] e1;
        logic [1:0] p0;
        logic [1:0] p1;
    } vec_t;

    localparam int NV = 13;
    localparam logic [38:0] TBL [NV] = '{
        {1'b1,1'b0,10'h155,2'b00,1'b1, 10'h000,10'h000,2'b00,2'b00},
        {1'b1,1'b1,10'h2AA,2'b00,1'b1, 10'h000,10'h000,2'b00,2'b00},
        {1'b1,1'b0,10'h3FF,2'b00,1'b1, 10'h000,10'h000,2'b00,2'b00},
        {1'b0,1'b0,10'h000,2'b00,1'b1, 10'h000,10'h000,2'b00,2'b00},
        {1'b1,1'b1,10'h0F0,2'b00,1'b0, 10'h3FF,10'h0F0,2'b00,2'b00},
        {1'b1,1'b0,10'h111,2'b00,1'b0, 10'h111,10'h0F0,2'b00,2'b00},
        {1'b1,1'b1,10'h222,2'b01,1'b1, 10'h111,10'h0F0,2'b00,2'b01},
        {1'b1,1'b0,10'h333,2'b10,1'b1, 10'h111,10'h0F0,2'b10,2'b01},
        {1'b1,1'b0,10'h044,2'b11,1'b0, 10'h044,10'h222,2'b11,2'b01},
        {1'b1,1'b1,10'h2AA,2'b11,1'b1, 10'h044,10'h222,2'b11,2'b11},
        {1'b1,1'b1,10'h2AA,2'b00,1'b1, 10'h044,10'h222,2'b11,2'b00},
        {1'b0,1'b0,10'h000,2'b00,1'b0, 10'h044,10'h222,2'b11,2'b00},
        {1'b1,1'b0,10'h100,2'b00,1'b0, 10'h100,10'h2AA,2'b00,2'b00}
    };

    string tags [NV];

    task automatic check(string tag, logic [19:0] ec, logic [3:0] ep);
        n_chk++;
        if (dac_code !== ec || pd_mode !== ep) begin
            n_fail++;
            $display("FAIL %s: code=%h mode=%b expected code=%h mode=%b",
                     tag, dac_code, pd_mode, ec, ep);
        end
    endtask

    task automatic drive(logic en, logic ch, logic [9:0] c, logic [1:0] p, logic h);
        wr_en = en; wr_chan = ch; wr_code = c; wr_pd = p; wr_hold = h;
    endtask

    initial begin
        tags[0]  = "R2 held write ch0";
        tags[1]  = "R2 held write ch1";
        tags[2]  = "R5 overwrite before load";
        tags[3]  = "R2 idle cycle";
        tags[4]  = "R3 R5 load moves both";
        tags[5]  = "R4 unwritten channel kept";
        tags[6]  = "R6 R7 mode 01 code kept";
        tags[7]  = "R6 R7 mode 10 code kept";
        tags[8]  = "R3 R6 load with mode 11";
        tags[9]  = "R6 R8 ch1 mode 11";
        tags[10] = "R6 back to normal";
        tags[11] = "R4 idle after stage";
        tags[12] = "R3 R8 pending ch1 follows";

        rst = 1'b1;
        drive(0, 0, 0, 0, 1);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", 20'h0, 4'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            drive(v.en, v.ch, v.code, v.pd, v.hold);
            @(negedge clk);
            check(tags[i], {v.e1, v.e0}, {v.p1, v.p0});
        end
        drive(0, 0, 0, 0, 1);

        // R1: reset in the middle of a busy state
        drive(1, 1, 10'h3AB, 2'b10, 1);
        @(negedge clk);
        drive(0, 0, 0, 0, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears outputs", 20'h0, 4'h0);

        // R1: staged code before reset must not transfer
        drive(1, 0, 10'h005, 2'b00, 0);
        @(negedge clk);
        drive(0, 0, 0, 0, 1);
        check("R1 pending cleared by reset", {10'h000, 10'h005}, 4'h0);

        // R4: second load without writes changes nothing
        drive(1, 0, 10'h005, 2'b00, 0);
        @(negedge clk);
        drive(0, 0, 0, 0, 1);
        check("R4 repeat load", {10'h000, 10'h005}, 4'h0);

        // R7 R8: ch1 mode only, codes still held
        drive(1, 1, 10'h1C3, 2'b01, 1);
        @(negedge clk);
        drive(0, 0, 0, 0, 1);
        check("R7 mode write keeps code", {10'h000, 10'h005}, 4'b0100);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule